// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits on the controller side of an SDRAM interface. On a request from a power manager it moves the memory into self-refresh, and on a later request it brings the memory back out. It owns the clock-enable pin and the command pins (chip select, row strobe, column strobe, write enable), the bank and address lines and the data masks for the whole sequence. When the sequence is done it gives a one-cycle ready pulse, after which the normal command scheduler may take the pins back.

Going in, the sequencer closes all banks with a precharge-all command. It waits out the precharge time. If burst mode was selected when the request was accepted, it then issues a fixed-length run of auto-refresh commands spaced by the row-cycle time. It ends with a refresh command in the same cycle that clock enable is pulled low. Coming out, it enforces a minimum time in self-refresh and waits for a clock-stable indication. It then raises clock enable and holds the bus in deselect for the exit recovery time. In burst mode it repeats the refresh run before it reports ready. All timing values are elaboration parameters given in clock cycles.

Top module: `sdr_sref_seq`

## Requirements
- R1: While reset is high, and in the idle state afterwards, clock enable is 1, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), the address, bank and data masks are 0, and busy and ready are 0.
- R2: An enter request seen in idle is accepted. In the next cycle busy rises and a precharge-all command is driven ({cs_n,ras_n,cas_n,we_n} = 0010 with address bit 10 high). Enter requests that arrive while busy is high have no effect on the sequence.
- R3: The first command after the precharge-all (a refresh or the entry command) comes exactly T_RP cycles after it. NOP is driven in the cycles between.
- R4: The entry command is refresh encoding 0001 driven in the same cycle that clock enable first goes low. Clock enable then stays low until the exit phase.
- R5: If burst mode is high in the cycle the enter request is accepted, N_BURST refresh commands (0001, clock enable high) are driven before entry and another N_BURST after exit recovery. They are spaced T_RC cycles apart, with NOP in the gaps. The entry command, or the ready cycle, follows the last refresh by T_RC cycles. Burst mode is ignored at every other time.
- R6: Clock enable rises no sooner than T_RAS cycles after the entry cycle, even if the exit request arrives at entry. An exit request that comes later raises clock enable in the cycle after it, once the dwell time has elapsed.
- R7: Clock enable rises only after a cycle in which the clock-stable input was high. Until then it stays low while an exit request is pending.
- R8: From the cycle in which clock enable rises, deselect (1111) is driven for T_XSR cycles.
- R9: Ready is high for exactly one cycle, and busy falls in that same cycle. Without burst mode this happens T_XSR cycles after clock enable rises. With burst mode it happens T_RC cycles after the last post-exit refresh.
- R10: While busy is high, all data-mask bits are 1. In every cycle after the entry cycle in which clock enable is low, deselect (1111) is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter self-refresh (sampled in idle) |
| exit_req | input | 1 | Request to leave self-refresh (pulse; held pending) |
| clk_stable | input | 1 | Memory clock is running and stable |
| burst_mode | input | 1 | Bracket self-refresh with refresh bursts (sampled at acceptance) |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address (held 0) |
| addr | output | ADDR_W | Address; bit 10 selects all banks for precharge |
| dqm | output | DQM_W | Data masks |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle pulse: normal commands may resume |

## Verification
A wrong state or a wrong counter value here shows up at the command pins within one cycle. A refresh or entry command lands a cycle early or late against a timeline the bench computes from T_RP, T_RC, T_RAS and T_XSR. A wrong burst count shifts the entry cycle and the ready pulse by a multiple of T_RC. A lost or stale exit request changes the cycle in which clock enable rises, and this is checked against the exit-request, dwell and clock-stable times. The bench compares every pin in every cycle of each sequence, so a wrong state is caught in the first cycle it drives wrong pins.

// File: rtl/sdr_sref_pkg.sv
package sdr_sref_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREALL,
        ST_RP_WAIT,
        ST_PRE_REF,
        ST_PRE_GAP,
        ST_ENTER,
        ST_SREF,
        ST_XSR_WAIT,
        ST_POST_REF,
        ST_POST_GAP,
        ST_DONE
    } sref_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP     = 4'b0111,
        CMD_DESEL   = 4'b1111,
        CMD_PREALL  = 4'b0010,
        CMD_REFRESH = 4'b0001
    } sdr_cmd_e;

    typedef struct packed {
        logic     cke;
        sdr_cmd_e cmd;
        logic     a10;
    } sdr_pins_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic sdr_pins_t pins_for(input sref_state_e st);
        sdr_pins_t p;
        p.cke = 1'b1;
        p.cmd = CMD_NOP;
        p.a10 = 1'b0;
        case (st)
            ST_PREALL: begin
                p.cmd = CMD_PREALL;
                p.a10 = 1'b1;
            end
            ST_PRE_REF, ST_POST_REF: p.cmd = CMD_REFRESH;
            ST_ENTER: begin
                p.cke = 1'b0;
                p.cmd = CMD_REFRESH;
            end
            ST_SREF: begin
                p.cke = 1'b0;
                p.cmd = CMD_DESEL;
            end
            ST_XSR_WAIT: p.cmd = CMD_DESEL;
            default: p.cmd = CMD_NOP;
        endcase
        return p;
    endfunction

    function automatic logic is_busy(input sref_state_e st);
        return (st != ST_IDLE) && (st != ST_DONE);
    endfunction

endpackage

// File: rtl/sref_wait_timer.sv
module sref_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

    // R3
    timer_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sref_burst_ctr.sv
module sref_burst_ctr #(
    parameter int N_BURST = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic incr,
    output logic all_done
);
    localparam int CW = $clog2(N_BURST + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (incr)    cnt <= cnt + 1'b1;
    end

    assign all_done = (cnt == CW'(N_BURST));

    // R5
    burst_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(N_BURST));

endmodule

// File: rtl/sdr_sref_seq.sv
module sdr_sref_seq
    import sdr_sref_pkg::*;
#(
    parameter int T_RP    = 3,
    parameter int T_RC    = 8,
    parameter int T_RAS   = 6,
    parameter int T_XSR   = 10,
    parameter int N_BURST = 4096,
    parameter int ADDR_W  = 12,
    parameter int BA_W    = 2,
    parameter int DQM_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              exit_req,
    input  logic              clk_stable,
    input  logic              burst_mode,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm,
    output logic              busy,
    output logic              ready
);
    // T_RP, T_RC, T_RAS must be >= 2; T_XSR >= 1; ADDR_W >= 11.
    localparam int MAXT = max4(T_RP, T_RC, T_RAS, T_XSR);
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 2);
    localparam logic [TW-1:0] RC_LD  = TW'(T_RC - 2);
    localparam logic [TW-1:0] RAS_LD = TW'(T_RAS - 2);
    localparam logic [TW-1:0] XSR_LD = TW'(T_XSR - 1);

    sref_state_e   st, nxt;
    logic          burst_q;
    logic          exit_pend;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          b_clr, b_inc, b_all;
    sdr_pins_t     pins;

    sref_wait_timer #(.W(TW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sref_burst_ctr #(.N_BURST(N_BURST)) burst_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (b_clr),
        .incr     (b_inc),
        .all_done (b_all)
    );

    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = '0;
        b_clr  = 1'b0;
        b_inc  = 1'b0;
        case (st)
            ST_IDLE: if (enter_req) begin
                nxt   = ST_PREALL;
                b_clr = 1'b1;
            end
            ST_PREALL: begin
                nxt    = ST_RP_WAIT;
                t_load = 1'b1;
                t_val  = RP_LD;
            end
            ST_RP_WAIT: if (t_zero) nxt = burst_q ? ST_PRE_REF : ST_ENTER;
            ST_PRE_REF: begin
                b_inc  = 1'b1;
                nxt    = ST_PRE_GAP;
                t_load = 1'b1;
                t_val  = RC_LD;
            end
            ST_PRE_GAP: if (t_zero) nxt = b_all ? ST_ENTER : ST_PRE_REF;
            ST_ENTER: begin
                nxt    = ST_SREF;
                t_load = 1'b1;
                t_val  = RAS_LD;
            end
            ST_SREF: if ((exit_pend || exit_req) && t_zero && clk_stable) begin
                nxt    = ST_XSR_WAIT;
                t_load = 1'b1;
                t_val  = XSR_LD;
                b_clr  = 1'b1;
            end
            ST_XSR_WAIT: if (t_zero) nxt = burst_q ? ST_POST_REF : ST_DONE;
            ST_POST_REF: begin
                b_inc  = 1'b1;
                nxt    = ST_POST_GAP;
                t_load = 1'b1;
                t_val  = RC_LD;
            end
            ST_POST_GAP: if (t_zero) nxt = b_all ? ST_DONE : ST_POST_REF;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            burst_q   <= 1'b0;
            exit_pend <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && enter_req) burst_q <= burst_mode;
            if (st == ST_ENTER || st == ST_SREF)
                exit_pend <= (exit_pend || exit_req) && (nxt != ST_XSR_WAIT);
            else
                exit_pend <= 1'b0;
        end
    end

    assign pins  = pins_for(st);
    assign cke   = pins.cke;
    assign {cs_n, ras_n, cas_n, we_n} = pins.cmd;
    assign ba    = '0;
    assign addr  = ADDR_W'(pins.a10) << 10;
    assign busy  = is_busy(st);
    assign dqm   = busy ? '1 : '0;
    assign ready = (st == ST_DONE);

    // Checker state: cycles spent with clock enable low.
    logic [15:0] low_age;
    always_ff @(posedge clk) begin
        if (rst || cke)         low_age <= '0;
        else if (low_age != '1) low_age <= low_age + 1'b1;
    end

    // R2
    prealL_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!cs_n && !ras_n && cas_n && !we_n && addr[10]));

    // R4
    entry_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

    // R10
    sref_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && !$past(cke)) |-> cs_n);

    // R6
    dwell_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (low_age >= 16'(T_RAS)));

    // R7
    clk_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(clk_stable));

    // R8
    exit_desel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> cs_n);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> !busy);

endmodule

// File: tb/sdr_sref_seq_tb_top.sv
module sdr_sref_seq_tb_top;
    localparam int P_RP  = 3;
    localparam int P_RC  = 4;
    localparam int P_RAS = 6;
    localparam int P_XSR = 5;
    localparam int P_N   = 3;
    localparam int AW    = 12;
    localparam int BW    = 2;
    localparam int DW    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enter_req = 1'b0, exit_req = 1'b0, clk_stable = 1'b1, burst_mode = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, busy, ready;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    logic [DW-1:0] dqm;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdr_sref_seq #(
        .T_RP(P_RP), .T_RC(P_RC), .T_RAS(P_RAS), .T_XSR(P_XSR),
        .N_BURST(P_N), .ADDR_W(AW), .BA_W(BW), .DQM_W(DW)
    ) dut_i (
        .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
        .clk_stable(clk_stable), .burst_mode(burst_mode),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dqm(dqm), .busy(busy), .ready(ready)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Pin vector: {busy, ready, cke, cs_n, ras_n, cas_n, we_n, a10, ba!=0, addr-other!=0}
    function automatic logic [31:0] pinvec();
        logic [AW-1:0] other;
        other = addr;
        other[10] = 1'b0;
        return {22'd0, busy, ready, cke, cs_n, ras_n, cas_n, we_n, addr[10], |ba, |other};
    endfunction

    function automatic logic [31:0] expvec(input bit b, input bit r, input bit k,
                                           input logic [3:0] cmd, input bit a10);
        return {22'd0, b, r, k, cmd, a10, 1'b0, 1'b0};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        cmp("R1 in reset", pinvec(), expvec(0, 0, 1, 4'b0111, 0));
        cmp("R1 dqm in reset", 32'(dqm), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        cmp("R1 idle after reset", pinvec(), expvec(0, 0, 1, 4'b0111, 0));
        cmp("R1 dqm idle", 32'(dqm), 32'd0);
    endtask

    // exit_off: cycle offset from entry at which exit_req pulses.
    // stable_off: -1 keeps clk_stable high; otherwise it rises at entry+stable_off.
    // enter_pulse: cycle index of a stray enter request (-1 for none).
    task automatic run_seq(input string name, input bit burst, input int exit_off,
                           input int stable_off, input int enter_pulse);
        int e, x, s, rise, done_t, post0;
        string tag;
        logic [3:0] ecmd;
        bit ek, ea, eb, er;
        e  = P_RP + (burst ? P_N * P_RC : 0);
        x  = e + exit_off;
        s  = (stable_off < 0) ? 0 : e + stable_off;
        rise = e + P_RAS;
        if (x + 1 > rise) rise = x + 1;
        if (stable_off >= 0 && s + 1 > rise) rise = s + 1;
        post0  = rise + P_XSR;
        done_t = post0 + (burst ? P_N * P_RC : 0);

        @(negedge clk);
        enter_req  = 1'b1;
        burst_mode = burst;
        clk_stable = (stable_off < 0);
        @(negedge clk);
        enter_req  = 1'b0;
        burst_mode = !burst;   // R5: changes after acceptance must not matter
        for (int t = 0; t <= done_t + 2; t++) begin
            ek = 1'b1; ea = 1'b0; eb = (t < done_t); er = (t == done_t);
            ecmd = 4'b0111;
            if (t == 0) begin
                ecmd = 4'b0010; ea = 1'b1; tag = "R2 precharge-all";
            end else if (t < e) begin
                tag = burst ? "R5 pre-entry burst" : "R3 precharge gap";
                if (burst && t >= P_RP && ((t - P_RP) % P_RC) == 0) ecmd = 4'b0001;
            end else if (t == e) begin
                ek = 1'b0; ecmd = 4'b0001; tag = "R4 entry command";
            end else if (t < rise) begin
                ek = 1'b0; ecmd = 4'b1111;
                tag = (stable_off >= 0) ? "R7 wait clock stable" : "R6 dwell";
            end else if (t < post0) begin
                ecmd = 4'b1111; tag = "R8 exit recovery";
            end else if (t < done_t) begin
                tag = "R5 post-exit burst";
                if (((t - post0) % P_RC) == 0) ecmd = 4'b0001;
            end else if (t == done_t) begin
                tag = "R9 ready pulse";
            end else begin
                tag = "R9 back to idle";
            end
            cmp({tag, " / ", name}, pinvec(), expvec(eb, er, ek, ecmd, ea));
            cmp({"R10 dqm / ", name}, 32'(dqm), eb ? 32'((1 << DW) - 1) : 32'd0);
            enter_req = (t == enter_pulse);
            exit_req  = (t == x);
            if (stable_off >= 0 && t == s) clk_stable = 1'b1;
            @(negedge clk);
        end
        enter_req  = 1'b0;
        exit_req   = 1'b0;
        clk_stable = 1'b1;
    endtask

    // R2 R3 R4 R6 R8 R9: plain entry, exit requested at entry, stray enter ignored
    task automatic test_plain_early_exit();
        run_seq("plain early exit", 1'b0, 0, -1, 2);
    endtask

    // R6 R8 R9: exit requested well after the dwell time
    task automatic test_plain_late_exit();
        run_seq("plain late exit", 1'b0, 12, -1, -1);
    endtask

    // R7: clock-stable held low long after the request
    task automatic test_clock_wait();
        run_seq("clock wait", 1'b0, 1, 20, -1);
    endtask

    // R5: burst refresh on both sides, stray enter during recovery
    task automatic test_burst();
        int e;
        e = P_RP + P_N * P_RC;
        run_seq("burst", 1'b1, 0, -1, e + P_RAS + 1);
    endtask

    // R5 R7: burst with late clock and late exit
    task automatic test_burst_late();
        run_seq("burst late", 1'b1, 9, 4, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
    end

    initial begin
        test_reset();
        test_plain_early_exit();
        test_plain_late_exit();
        test_clock_wait();
        test_burst();
        test_burst_late();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule